// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block sits behind a line receiver's clock and data recovery and decides whether a usable signal is present. Once per recovered bit period it is given a one-cycle enable together with an indication of whether a mark (a received one) was seen in that bit. From that stream it keeps a single loss status. The status is high out of reset. It goes high again after a long unbroken run of zero bits. It goes low only when a short span of bits holds enough marks, with no long zero gap inside that span.

While the status is high, the positive and negative receive data paths are held at zero, so downstream framing logic sees silence instead of noise. A bypass input lets data through regardless, for configurations where the data path does not pass through the elastic store. Every change of the status, in either direction, sets a sticky change flag. That flag drives an active-low interrupt request. The request can be masked without losing the flag. The flag is cleared by a one-cycle strobe, which is the clear that goes with a register read or a write of one.

The assert and release rules are deliberately lopsided. Asserting needs 175 zero bits. Releasing needs three marks whose total span, first mark to third mark inclusive, is at most 32 bits. A candidate span is abandoned if 16 zeros in a row occur inside it. It is also abandoned if it reaches 32 bits without the third mark.

Top module: `los_monitor`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), los_out is 1, chg_flag_out is 0, irq_n_out is 1, and rx_pos_out and rx_neg_out are 0 while bypass_in is 0.
- R2: A bit period is a clock cycle with bit_en_in high. los_out becomes 1 at the clock edge that registers the 175th consecutive zero bit (mark_in low). After 174 consecutive zero bits, a los_out that was 0 stays 0.
- R3: Cycles with bit_en_in low neither add to nor reset the zero run. A bit period with mark_in high resets the run to zero. The run count saturates and does not wrap.
- R4: While los_out is 1, a candidate span opens on a mark bit. los_out becomes 0 at the clock edge that registers the third mark of the span, provided the span from first to third mark inclusive is at most 32 bit periods.
- R5: Inside an open span, a run of 15 zero bits is allowed. The 16th consecutive zero bit abandons the span, and marks already counted in it are forgotten.
- R6: A span that reaches 32 bit periods without its third mark is abandoned. A later mark opens a new span counted from one. If the 32nd bit is itself a mark, that mark opens the new span.
- R7: rx_pos_out and rx_neg_out equal rx_pos_in and rx_neg_in when los_out is 0 or bypass_in is 1; otherwise both are 0.
- R8: Each change of los_out sets chg_flag_out to 1 at the same edge. irq_n_out is the inverse of (chg_flag_out AND NOT irq_mask_in), so masking hides the request but keeps the flag.
- R9: chg_flag_out stays 1 until a clock edge with irq_clr_in high. If a status change occurs at the same edge as the clear, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en_in | input | 1 | One-cycle enable per recovered bit period |
| mark_in | input | 1 | Mark seen in this bit period (valid with bit_en_in) |
| rx_pos_in | input | 1 | Positive-rail (or combined) receive data |
| rx_neg_in | input | 1 | Negative-rail receive data |
| bypass_in | input | 1 | 1 lets data pass while loss is asserted |
| irq_mask_in | input | 1 | 1 masks the interrupt request |
| irq_clr_in | input | 1 | One-cycle strobe clearing the change flag |
| los_out | output | 1 | Loss-of-signal status, 1 = loss |
| rx_pos_out | output | 1 | Gated positive-rail receive data |
| rx_neg_out | output | 1 | Gated negative-rail receive data |
| irq_n_out | output | 1 | Active-low interrupt request |
| chg_flag_out | output | 1 | Sticky status-change register bit |

## Verification
A wrong zero-run count shows as los_out rising one or more bit periods early or late around the 175-bit mark. This is visible at the edge after the offending bit, so the bench checks the 174th and 175th zero separately. A stale mark count or span length shows as a release one mark too early, after a 16-zero gap or after a span timeout. The bench puts a check right after each such mark. A flag that fails to hold, or a clear that wins over a same-edge status change, shows at irq_n_out within one cycle.

// File: rtl/los_pkg.sv
// Package: shared type for the release-span tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package los_pkg;
    typedef enum logic {
        SPAN_IDLE = 1'b0,
        SPAN_OPEN = 1'b1
    } span_state_e;
endpackage

// File: rtl/los_zero_run.sv
// Module: los_zero_run
// Counts consecutive zero bit periods, saturating at ASSERT_ZEROS, and
// pulses run_hit_o on the bit period that completes the run.
// Assumes: bit_en_i is high for exactly one clock per bit period.
module los_zero_run #(
    parameter int ASSERT_ZEROS = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en_i,
    input  logic mark_i,
    output logic run_hit_o
);
    localparam int ZW = $clog2(ASSERT_ZEROS + 1);
    localparam logic [ZW-1:0] Z_LAST = ZW'(ASSERT_ZEROS - 1);
    localparam logic [ZW-1:0] Z_SAT  = ZW'(ASSERT_ZEROS);

    logic [ZW-1:0] zcnt_q;

    // completion of the zero run on this bit period
    assign run_hit_o = bit_en_i && !mark_i && (zcnt_q == Z_LAST);

    // zero-run counter: cleared by marks, saturates at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zcnt_q <= '0;
        end else if (bit_en_i) begin
            if (mark_i) begin
                zcnt_q <= '0;
            end else if (zcnt_q != Z_SAT) begin
                zcnt_q <= zcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/los_release_win.sv
// Module: los_release_win
// While armed_i is high, tracks a candidate span opened by a mark and
// pulses release_o on the bit that brings MIN_MARKS marks within
// WIN_LEN bit periods. A zero run above MAX_GAP or a span reaching
// WIN_LEN bits abandons the span; a mark on the abandoning bit reopens it.
// Assumes: MIN_MARKS >= 2, WIN_LEN > MIN_MARKS.
module los_release_win
    import los_pkg::*;
#(
    parameter int WIN_LEN   = 32,
    parameter int MIN_MARKS = 3,
    parameter int MAX_GAP   = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic bit_en_i,
    input  logic mark_i,
    output logic release_o
);
    localparam int WW = $clog2(WIN_LEN + 1);
    localparam int MW = $clog2(MIN_MARKS + 1);
    localparam int GW = $clog2(MAX_GAP + 2);
    localparam logic [WW-1:0] W_END = WW'(WIN_LEN);
    localparam logic [MW-1:0] M_TGT = MW'(MIN_MARKS);
    localparam logic [GW-1:0] G_MAX = GW'(MAX_GAP);

    span_state_e   st_q, st_d;
    logic [WW-1:0] wcnt_q, wcnt_d, w_inc;
    logic [MW-1:0] mcnt_q, mcnt_d, m_inc;
    logic [GW-1:0] gap_q, gap_d, g_inc;

    // candidate values if the current bit is taken into the span
    always_comb begin
        w_inc = wcnt_q + 1'b1;
        m_inc = mcnt_q + MW'(mark_i);
        g_inc = mark_i ? '0 : (gap_q + 1'b1);
    end

    // span decision for this cycle
    always_comb begin
        st_d      = st_q;
        wcnt_d    = wcnt_q;
        mcnt_d    = mcnt_q;
        gap_d     = gap_q;
        release_o = 1'b0;
        if (!armed_i) begin
            st_d   = SPAN_IDLE;
            wcnt_d = '0;
            mcnt_d = '0;
            gap_d  = '0;
        end else if (bit_en_i) begin
            if (st_q == SPAN_IDLE) begin
                if (mark_i) begin
                    st_d   = SPAN_OPEN;
                    wcnt_d = WW'(1);
                    mcnt_d = MW'(1);
                    gap_d  = '0;
                end
            end else if (m_inc == M_TGT) begin
                release_o = 1'b1;
                st_d      = SPAN_IDLE;
                wcnt_d    = '0;
                mcnt_d    = '0;
                gap_d     = '0;
            end else if ((g_inc > G_MAX) || (w_inc == W_END)) begin
                st_d   = mark_i ? SPAN_OPEN : SPAN_IDLE;
                wcnt_d = mark_i ? WW'(1) : '0;
                mcnt_d = mark_i ? MW'(1) : '0;
                gap_d  = '0;
            end else begin
                wcnt_d = w_inc;
                mcnt_d = m_inc;
                gap_d  = g_inc;
            end
        end
    end

    // span state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SPAN_IDLE;
            wcnt_q <= '0;
            mcnt_q <= '0;
            gap_q  <= '0;
        end else begin
            st_q   <= st_d;
            wcnt_q <= wcnt_d;
            mcnt_q <= mcnt_d;
            gap_q  <= gap_d;
        end
    end
endmodule

// File: rtl/los_irq.sv
// Module: los_irq
// Sticky change flag with clear strobe and maskable active-low request.
// Assumes: change_i and clr_i are single-cycle events; a change wins.
module los_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic change_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic flag_o,
    output logic irq_n_o
);
    logic flag_q;

    // sticky flag: set on change, cleared by strobe, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (change_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o  = flag_q;
    assign irq_n_o = !(flag_q && !mask_i);
endmodule

// File: rtl/los_monitor.sv
// Module: los_monitor (top)
// Loss-of-signal status for a recovered bit stream: asserted at reset and
// after ASSERT_ZEROS zero bits, released by the span rule in
// los_release_win. Gates receive data while in loss and raises a
// maskable change interrupt.
// Assumes: one bit_en_in pulse per bit period, mark_in valid with it.
module los_monitor #(
    parameter int ASSERT_ZEROS = 175,
    parameter int WIN_LEN      = 32,
    parameter int MIN_MARKS    = 3,
    parameter int MAX_GAP      = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en_in,
    input  logic mark_in,
    input  logic rx_pos_in,
    input  logic rx_neg_in,
    input  logic bypass_in,
    input  logic irq_mask_in,
    input  logic irq_clr_in,
    output logic los_out,
    output logic rx_pos_out,
    output logic rx_neg_out,
    output logic irq_n_out,
    output logic chg_flag_out
);
    logic los_q;
    logic run_hit;
    logic rel_hit;
    logic los_change;
    logic pass_en;

    los_zero_run #(
        .ASSERT_ZEROS(ASSERT_ZEROS)
    ) u_zero (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en_i (bit_en_in),
        .mark_i   (mark_in),
        .run_hit_o(run_hit)
    );

    los_release_win #(
        .WIN_LEN  (WIN_LEN),
        .MIN_MARKS(MIN_MARKS),
        .MAX_GAP  (MAX_GAP)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed_i  (los_q),
        .bit_en_i (bit_en_in),
        .mark_i   (mark_in),
        .release_o(rel_hit)
    );

    // status change event in either direction
    assign los_change = (run_hit && !los_q) || (rel_hit && los_q);

    // loss status register, high out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            los_q <= 1'b1;
        end else if (run_hit) begin
            los_q <= 1'b1;
        end else if (rel_hit) begin
            los_q <= 1'b0;
        end
    end

    los_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .change_i(los_change),
        .clr_i   (irq_clr_in),
        .mask_i  (irq_mask_in),
        .flag_o  (chg_flag_out),
        .irq_n_o (irq_n_out)
    );

    // receive data gating
    assign pass_en    = !los_q || bypass_in;
    assign rx_pos_out = rx_pos_in && pass_en;
    assign rx_neg_out = rx_neg_in && pass_en;
    assign los_out    = los_q;
endmodule

// File: rtl/los_monitor_chk.sv
// Module: los_monitor_chk
// Assertion checker bound into los_monitor. Keeps its own zero-run model.
module los_monitor_chk #(
    parameter int ASSERT_ZEROS = 175
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en_in,
    input logic mark_in,
    input logic rx_pos_out,
    input logic rx_neg_out,
    input logic bypass_in,
    input logic irq_mask_in,
    input logic irq_clr_in,
    input logic los_out,
    input logic irq_n_out,
    input logic chg_flag_out
);
    int zmodel;

    // independent zero-run model
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zmodel <= 0;
        end else if (bit_en_in) begin
            if (mark_in) zmodel <= 0;
            else if (zmodel < ASSERT_ZEROS) zmodel <= zmodel + 1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (los_out && !chg_flag_out));

    p_run_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_in && !mark_in && zmodel == ASSERT_ZEROS - 1) |=> los_out);

    p_rise_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_out) |-> $past(bit_en_in && !mark_in));

    p_fall_on_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_out) |-> $past(bit_en_in && mark_in));

    p_gate_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (los_out && !bypass_in) |-> (!rx_pos_out && !rx_neg_out));

    p_flag_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (los_out != $past(los_out)) |-> chg_flag_out);

    p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag_out && !irq_clr_in) |=> chg_flag_out);

    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag_out && !irq_mask_in) |-> !irq_n_out);
endmodule

bind los_monitor los_monitor_chk #(
    .ASSERT_ZEROS(ASSERT_ZEROS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en_in   (bit_en_in),
    .mark_in     (mark_in),
    .rx_pos_out  (rx_pos_out),
    .rx_neg_out  (rx_neg_out),
    .bypass_in   (bypass_in),
    .irq_mask_in (irq_mask_in),
    .irq_clr_in  (irq_clr_in),
    .los_out     (los_out),
    .irq_n_out   (irq_n_out),
    .chg_flag_out(chg_flag_out)
);

// File: tb/tb_los_monitor.sv
// Directed bench for los_monitor: one task per scenario.
module tb_los_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en_in = 1'b0, mark_in = 1'b0;
    logic rx_pos_in = 1'b0, rx_neg_in = 1'b0;
    logic bypass_in = 1'b0, irq_mask_in = 1'b0, irq_clr_in = 1'b0;
    logic los_out, rx_pos_out, rx_neg_out, irq_n_out, chg_flag_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    los_monitor dut (
        .clk(clk), .rst_n(rst_n), .bit_en_in(bit_en_in), .mark_in(mark_in),
        .rx_pos_in(rx_pos_in), .rx_neg_in(rx_neg_in), .bypass_in(bypass_in),
        .irq_mask_in(irq_mask_in), .irq_clr_in(irq_clr_in),
        .los_out(los_out), .rx_pos_out(rx_pos_out), .rx_neg_out(rx_neg_out),
        .irq_n_out(irq_n_out), .chg_flag_out(chg_flag_out)
    );

    task automatic check(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // one bit period: enable high for one cycle, sampled at the next negedge
    task automatic send_bit(input logic m, input logic clr = 1'b0);
        @(negedge clk);
        bit_en_in  = 1'b1;
        mark_in    = m;
        irq_clr_in = clr;
        @(negedge clk);
        bit_en_in  = 1'b0;
        mark_in    = 1'b0;
        irq_clr_in = 1'b0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr_in = 1'b1;
        @(negedge clk);
        irq_clr_in = 1'b0;
    endtask

    task automatic t_reset();
        rx_pos_in = 1'b1;
        rx_neg_in = 1'b1;
        #1;
        check(los_out, 1'b1, "R1 los after reset");
        check(chg_flag_out, 1'b0, "R1 flag after reset");
        check(irq_n_out, 1'b1, "R1 irq_n after reset");
        check(rx_pos_out, 1'b0, "R1/R7 pos gated in reset state");
        check(rx_neg_out, 1'b0, "R1/R7 neg gated in reset state");
    endtask

    task automatic t_basic_release();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check(los_out, 1'b1, "R4 two marks keep loss");
        send_bit(1'b0); send_bit(1'b1);
        check(los_out, 1'b0, "R4 third mark releases");
        check(chg_flag_out, 1'b1, "R8 flag on release");
        check(irq_n_out, 1'b0, "R8 irq on release");
        check(rx_pos_out, 1'b1, "R7 pos passes when clear");
        check(rx_neg_out, 1'b1, "R7 neg passes when clear");
        repeat (3) @(negedge clk);
        check(chg_flag_out, 1'b1, "R9 flag holds without clear");
        clear_irq();
        check(chg_flag_out, 1'b0, "R9 clear strobe");
        check(irq_n_out, 1'b1, "R9 irq released by clear");
    endtask

    task automatic t_assert_run();
        send_zeros(174);
        check(los_out, 1'b0, "R2 174 zeros keep clear");
        send_bit(1'b0);
        check(los_out, 1'b1, "R2 175th zero asserts");
        check(irq_n_out, 1'b0, "R8 irq on assert");
        clear_irq();
    endtask

    task automatic t_run_reset_and_idle();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        check(los_out, 1'b0, "R4 release before run test");
        clear_irq();
        send_zeros(100);
        send_bit(1'b1);
        send_zeros(170);
        repeat (40) @(negedge clk);
        send_zeros(4);
        check(los_out, 1'b0, "R3 mark reset run and idle cycles not counted");
        send_bit(1'b0);
        check(los_out, 1'b1, "R3 run reaches limit after mark");
        send_zeros(300);
        check(los_out, 1'b1, "R3 saturated run stays asserted");
        clear_irq();
    endtask

    task automatic t_span_edge();
        send_bit(1'b1); send_zeros(15); send_bit(1'b1); send_zeros(14);
        check(los_out, 1'b1, "R5 two marks with 15-gap keep loss");
        send_bit(1'b1);
        check(los_out, 1'b0, "R4/R5 32-bit span with 15-zero gap releases");
        clear_irq();
        send_zeros(175);
        check(los_out, 1'b1, "R2 reassert after span test");
        clear_irq();
    endtask

    task automatic t_gap16();
        send_bit(1'b1); send_bit(1'b1); send_zeros(16);
        send_bit(1'b1);
        check(los_out, 1'b1, "R5 16-zero gap discards earlier marks");
        send_bit(1'b1);
        check(los_out, 1'b1, "R5 second mark of new span");
        send_bit(1'b1);
        check(los_out, 1'b0, "R5 third mark of new span releases");
        clear_irq();
        send_zeros(175);
        clear_irq();
    endtask

    task automatic t_timeout();
        send_bit(1'b1); send_zeros(15); send_bit(1'b1); send_zeros(15);
        check(los_out, 1'b1, "R6 span of 32 with two marks");
        send_bit(1'b1);
        check(los_out, 1'b1, "R6 mark after timeout opens new span");
        send_bit(1'b1);
        check(los_out, 1'b1, "R6 second mark of new span");
        send_bit(1'b1);
        check(los_out, 1'b0, "R6 third mark of new span releases");
        clear_irq();
        send_zeros(175);
        clear_irq();
    endtask

    task automatic t_bypass_mask_priority();
        bypass_in = 1'b1;
        #1;
        check(rx_pos_out, 1'b1, "R7 bypass passes pos in loss");
        check(rx_neg_out, 1'b1, "R7 bypass passes neg in loss");
        bypass_in   = 1'b0;
        irq_mask_in = 1'b1;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        check(chg_flag_out, 1'b1, "R8 masked change still sets flag");
        check(irq_n_out, 1'b1, "R8 mask hides request");
        irq_mask_in = 1'b0;
        #1;
        check(irq_n_out, 1'b0, "R8 unmask shows request");
        clear_irq();
        send_zeros(174);
        send_bit(1'b0, 1'b1);
        check(los_out, 1'b1, "R2 assert with clear same edge");
        check(chg_flag_out, 1'b1, "R9 change wins over clear");
        check(irq_n_out, 1'b0, "R9 irq kept when change wins");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_release();
        t_assert_run();
        t_run_reset_and_idle();
        t_span_edge();
        t_gap16();
        t_timeout();
        t_bypass_mask_priority();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule